// File: doc/BRIEF.md
# Capability-Checked Data Address Unit

This unit turns a raw access address into a checked virtual address under the default data capability. That capability is the one held in capability register 0. The caller supplies the capability's fields for each request: a validity tag, a sealed flag, execute, load and store permission bits, and 64-bit base, offset and length values. The caller also gives the access kind (fetch, load or store), an access width and the raw address.

The unit works out the cursor as base plus offset, wrapped to 64 bits, and then adds the raw address to it. It runs four checks in a fixed priority order:

1. The tag must be set.
2. The capability must not be sealed.
3. The permission that matches the access kind must be present.
4. The access must lie inside the bounds.

The bounds check keeps the carries above bit 63, so an access cannot slip past the limit by wrapping around. The result is registered. One cycle after each request, a single response appears that carries either the 64-bit effective address or a fault with an exception code and the register number. Translating the address through a TLB and delivering the exception are left to the logic around this unit.

Top module: `cap_addr_unit`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after each cycle with `req_valid_i` high, and low otherwise. When no request is made, `rsp_addr_o`, `rsp_fault_o` and `rsp_exc_code_o` keep their previous values.
- R2: A request whose capability tag is 0 faults with code 0x02, whatever the state of every other input.
- R3: A request with the tag set and the sealed flag set faults with code 0x03.
- R4: With the tag set and the capability unsealed, the access kind selects the required permission. Kind 0 (fetch) needs execute and faults with 0x11 without it. Kind 1 (load) needs load and faults with 0x12. Kind 2 (store) needs store and faults with 0x13. Kind 3 is checked as a store.
- R5: The access width code 0, 1, 2 or 3 selects an access size of 1, 2, 4 or 8 bytes.
- R6: The cursor is (base + offset) mod 2^64. The virtual address is cursor + raw address, computed without wrap. On success, `rsp_addr_o` is the low 64 bits of the virtual address.
- R7: When the first three checks pass, a length violation with code 0x01 is raised in either of two cases: virtual address + size > base + length, or virtual address < base. Both comparisons use unwrapped arithmetic of at least 66 bits.
- R8: A faulting response has `rsp_fault_o`=1, `rsp_reg_num_o`=0 and `rsp_addr_o`=0. A successful response has `rsp_fault_o`=0, `rsp_exc_code_o`=0x00 and `rsp_reg_num_o`=0.
- R9: While reset is asserted and after it is released, every output is 0 until the first response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| acc_kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 store |
| acc_width_i | input | 2 | Size code: 1 << code bytes |
| raw_addr_i | input | 64 | Raw address added to the cursor |
| cap_tag_i | input | 1 | Capability tag |
| cap_sealed_i | input | 1 | Capability sealed flag |
| cap_perm_exec_i | input | 1 | Execute permission |
| cap_perm_load_i | input | 1 | Load permission |
| cap_perm_store_i | input | 1 | Store permission |
| cap_base_i | input | 64 | Capability base |
| cap_offset_i | input | 64 | Capability offset |
| cap_length_i | input | 64 | Capability length |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_fault_o | output | 1 | Response is a violation |
| rsp_addr_o | output | 64 | Checked effective address (0 on fault) |
| rsp_exc_code_o | output | 8 | Exception code (0x00 on success) |
| rsp_reg_num_o | output | 8 | Register number reported (0) |

## Verification
A single request can break several rules at once. For example, a missing permission can combine with an out-of-bounds address, a cleared tag with a sealed flag, or a wrapped cursor with a carry that passes bit 63. Only the highest-priority violation may be reported in such a case.

The bench provokes these overlaps with a sweep over every combination of tag, seal and the three permissions, every access kind and every width, taken against eight address scenarios. Some scenarios pass, some sit exactly at the upper limit, some fall below base, and some wrap past 2^64 in the cursor or in the virtual address. For each request the bench computes in wide arithmetic which single code must win, and the address that must be reported when the request passes.

// File: rtl/cap_addr_pkg.sv
package cap_addr_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_STX   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic exec;
    logic load;
    logic store;
  } cap_perm_t;

  localparam logic [7:0] EXC_NONE   = 8'h00;
  localparam logic [7:0] EXC_LENGTH = 8'h01;
  localparam logic [7:0] EXC_TAG    = 8'h02;
  localparam logic [7:0] EXC_SEAL   = 8'h03;
  localparam logic [7:0] EXC_EXEC   = 8'h11;
  localparam logic [7:0] EXC_LOAD   = 8'h12;
  localparam logic [7:0] EXC_STORE  = 8'h13;
endpackage

// File: rtl/cap_perm_check.sv
module cap_perm_check
  import cap_addr_pkg::*;
(
  input  logic      tag_i,
  input  logic      sealed_i,
  input  cap_perm_t perm_i,
  input  logic [1:0] kind_i,
  output logic      fault_o,
  output logic [7:0] code_o
);
  acc_kind_e kind;
  logic      perm_ok;
  logic [7:0] perm_code;

  assign kind = acc_kind_e'(kind_i);

  always_comb begin
    unique case (kind)
      ACC_FETCH: begin perm_ok = perm_i.exec;  perm_code = EXC_EXEC;  end
      ACC_LOAD:  begin perm_ok = perm_i.load;  perm_code = EXC_LOAD;  end
      default:   begin perm_ok = perm_i.store; perm_code = EXC_STORE; end
    endcase
  end

  // fixed priority: tag, seal, permission
  always_comb begin
    fault_o = 1'b1;
    if (!tag_i)        code_o = EXC_TAG;
    else if (sealed_i) code_o = EXC_SEAL;
    else if (!perm_ok) code_o = perm_code;
    else begin
      fault_o = 1'b0;
      code_o  = EXC_NONE;
    end
  end
endmodule

// File: rtl/cap_bounds_check.sv
module cap_bounds_check #(
  parameter int unsigned AW      = 64,
  parameter int unsigned WIDTH_W = 2
) (
  input  logic [AW-1:0]      base_i,
  input  logic [AW-1:0]      offset_i,
  input  logic [AW-1:0]      length_i,
  input  logic [AW-1:0]      raw_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               fault_o,
  output logic [AW-1:0]      vaddr_o
);
  localparam int unsigned XW     = AW + 2;
  localparam int unsigned NSIZES = 1 << WIDTH_W;

  logic [AW-1:0] cursor;
  logic [AW:0]   vaddr_x;
  logic [AW:0]   limit_x;
  logic [XW-1:0] end_x;
  logic [XW-1:0] size_tbl [NSIZES];
  logic [XW-1:0] size_x;

  for (genvar i = 0; i < NSIZES; i++) begin : g_size
    assign size_tbl[i] = XW'(1) << i;
  end

  assign size_x  = size_tbl[width_i];
  assign cursor  = base_i + offset_i;
  assign vaddr_x = {1'b0, cursor} + {1'b0, raw_i};
  assign limit_x = {1'b0, base_i} + {1'b0, length_i};
  assign end_x   = {1'b0, vaddr_x} + size_x;

  assign fault_o = (end_x > {1'b0, limit_x}) || (vaddr_x < {1'b0, base_i});
  assign vaddr_o = vaddr_x[AW-1:0];
endmodule

// File: rtl/cap_rsp_reg.sv
module cap_rsp_reg #(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fault_i,
  input  logic [7:0]    code_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    reg_num_i,
  output logic          valid_o,
  output logic          fault_o,
  output logic [7:0]    code_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    reg_num_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      fault_o   <= 1'b0;
      code_o    <= '0;
      addr_o    <= '0;
      reg_num_o <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        fault_o   <= fault_i;
        code_o    <= code_i;
        addr_o    <= addr_i;
        reg_num_o <= reg_num_i;
      end
    end
  end
endmodule

// File: rtl/cap_addr_unit.sv
module cap_addr_unit
  import cap_addr_pkg::*;
#(
  parameter int unsigned AW      = 64,
  parameter int unsigned WIDTH_W = 2,
  parameter logic [7:0]  CAP_IDX = 8'd0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    acc_kind_i,
  input  logic [1:0]    acc_width_i,
  input  logic [63:0]   raw_addr_i,
  input  logic          cap_tag_i,
  input  logic          cap_sealed_i,
  input  logic          cap_perm_exec_i,
  input  logic          cap_perm_load_i,
  input  logic          cap_perm_store_i,
  input  logic [63:0]   cap_base_i,
  input  logic [63:0]   cap_offset_i,
  input  logic [63:0]   cap_length_i,
  output logic          rsp_valid_o,
  output logic          rsp_fault_o,
  output logic [63:0]   rsp_addr_o,
  output logic [7:0]    rsp_exc_code_o,
  output logic [7:0]    rsp_reg_num_o
);
  cap_perm_t     perm;
  logic          perm_fault;
  logic [7:0]    perm_code;
  logic          bnd_fault;
  logic [AW-1:0] vaddr;
  logic          fault;
  logic [7:0]    code;
  logic [AW-1:0] addr;

  assign perm = '{exec: cap_perm_exec_i, load: cap_perm_load_i, store: cap_perm_store_i};

  cap_perm_check u_perm (
    .tag_i    (cap_tag_i),
    .sealed_i (cap_sealed_i),
    .perm_i   (perm),
    .kind_i   (acc_kind_i),
    .fault_o  (perm_fault),
    .code_o   (perm_code)
  );

  cap_bounds_check #(.AW(AW), .WIDTH_W(WIDTH_W)) u_bnd (
    .base_i   (cap_base_i[AW-1:0]),
    .offset_i (cap_offset_i[AW-1:0]),
    .length_i (cap_length_i[AW-1:0]),
    .raw_i    (raw_addr_i[AW-1:0]),
    .width_i  (acc_width_i[WIDTH_W-1:0]),
    .fault_o  (bnd_fault),
    .vaddr_o  (vaddr)
  );

  // bounds only matter once tag, seal and permission pass
  always_comb begin
    if (perm_fault) begin
      fault = 1'b1;
      code  = perm_code;
    end else if (bnd_fault) begin
      fault = 1'b1;
      code  = EXC_LENGTH;
    end else begin
      fault = 1'b0;
      code  = EXC_NONE;
    end
    addr = fault ? '0 : vaddr;
  end

  logic [AW-1:0] addr_q;

  cap_rsp_reg #(.AW(AW)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (req_valid_i),
    .fault_i   (fault),
    .code_i    (code),
    .addr_i    (addr),
    .reg_num_i (CAP_IDX),
    .valid_o   (rsp_valid_o),
    .fault_o   (rsp_fault_o),
    .code_o    (rsp_exc_code_o),
    .addr_o    (addr_q),
    .reg_num_o (rsp_reg_num_o)
  );

  assign rsp_addr_o = 64'(addr_q);
endmodule

// File: rtl/cap_addr_unit_chk.sv
module cap_addr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [1:0]  acc_kind_i,
  input logic        cap_tag_i,
  input logic        cap_sealed_i,
  input logic        cap_perm_exec_i,
  input logic        rsp_valid_o,
  input logic        rsp_fault_o,
  input logic [63:0] rsp_addr_o,
  input logic [7:0]  rsp_exc_code_o,
  input logic [7:0]  rsp_reg_num_o
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_exc_code_o));
  // R2
  tag_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cap_tag_i) |=> (rsp_fault_o && rsp_exc_code_o == 8'h02));
  // R3
  seal_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cap_tag_i && cap_sealed_i) |=> (rsp_fault_o && rsp_exc_code_o == 8'h03));
  // R4
  fetch_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cap_tag_i && !cap_sealed_i && acc_kind_i == 2'd0 && !cap_perm_exec_i)
      |=> (rsp_exc_code_o == 8'h11));
  // R8
  fault_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_addr_o == 64'd0 && rsp_exc_code_o != 8'h00));
  // R8
  pass_code_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_exc_code_o == 8'h00 && rsp_reg_num_o == 8'h00));
endmodule

bind cap_addr_unit cap_addr_unit_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .acc_kind_i     (acc_kind_i),
  .cap_tag_i      (cap_tag_i),
  .cap_sealed_i   (cap_sealed_i),
  .cap_perm_exec_i(cap_perm_exec_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_fault_o    (rsp_fault_o),
  .rsp_addr_o     (rsp_addr_o),
  .rsp_exc_code_o (rsp_exc_code_o),
  .rsp_reg_num_o  (rsp_reg_num_o)
);

// File: tb/cap_addr_unit_test.sv
module cap_addr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  acc_kind_i = '0;
  logic [1:0]  acc_width_i = '0;
  logic [63:0] raw_addr_i = '0;
  logic        cap_tag_i = 1'b0;
  logic        cap_sealed_i = 1'b0;
  logic        cap_perm_exec_i = 1'b0;
  logic        cap_perm_load_i = 1'b0;
  logic        cap_perm_store_i = 1'b0;
  logic [63:0] cap_base_i = '0;
  logic [63:0] cap_offset_i = '0;
  logic [63:0] cap_length_i = '0;
  logic        rsp_valid_o;
  logic        rsp_fault_o;
  logic [63:0] rsp_addr_o;
  logic [7:0]  rsp_exc_code_o;
  logic [7:0]  rsp_reg_num_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cap_addr_unit uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scenario table: base, offset, length, raw
  function automatic void scen(input int s, output logic [63:0] b, output logic [63:0] o,
                               output logic [63:0] l, output logic [63:0] r);
    case (s)
      0: begin b = 64'h1000; o = 64'h10; l = 64'h100; r = 64'h0; end
      1: begin b = 64'h1000; o = 64'h10; l = 64'h100; r = 64'hEC; end  // upper edge
      2: begin b = 64'h1000; o = -64'sd32; l = 64'h100; r = 64'h0; end // below base
      3: begin b = 64'h1000; o = -64'sd32; l = 64'h100; r = 64'h20; end // cursor wraps
      4: begin b = -64'sd16; o = 64'h0; l = 64'd32; r = 64'd20; end   // vaddr past 2^64
      5: begin b = -64'sd16; o = 64'h0; l = 64'd32; r = 64'd28; end
      6: begin b = 64'h2000; o = 64'h0; l = 64'h0; r = 64'h0; end
      default: begin b = 64'h1000; o = 64'h0; l = 64'h100; r = '1; end
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] b, o, l, r, last_addr;
    logic [65:0] cur, va, lim, en;
    logic [7:0]  ecode;
    logic [63:0] eaddr;
    logic        pok;
    string       tag;

    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 valid", 64'(rsp_valid_o), 0);
    check("R9 fault", 64'(rsp_fault_o), 0);
    check("R9 addr", rsp_addr_o, 0);
    check("R9 code", 64'(rsp_exc_code_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 after release", 64'(rsp_valid_o), 0);

    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 4; k++) begin
        for (int w = 0; w < 4; w++) begin  // R5 width codes
          for (int f = 0; f < 32; f++) begin
            scen(s, b, o, l, r);
            req_valid_i = 1'b1;
            acc_kind_i = 2'(k);
            acc_width_i = 2'(w);
            raw_addr_i = r;
            cap_base_i = b;
            cap_offset_i = o;
            cap_length_i = l;
            cap_tag_i = f[0];
            cap_sealed_i = f[1];
            cap_perm_exec_i = f[2];
            cap_perm_load_i = f[3];
            cap_perm_store_i = f[4];

            cur = 66'(64'(b + o));
            va  = cur + 66'(r);
            lim = 66'(b) + 66'(l);
            en  = va + (66'd1 << w);
            pok = (k == 0) ? f[2] : (k == 1) ? f[3] : f[4];
            eaddr = 64'h0;
            if (!f[0])        begin ecode = 8'h02; tag = "R2"; end
            else if (f[1])    begin ecode = 8'h03; tag = "R3"; end
            else if (!pok)    begin ecode = (k == 0) ? 8'h11 : (k == 1) ? 8'h12 : 8'h13; tag = "R4"; end
            else if (en > lim || va < 66'(b)) begin ecode = 8'h01; tag = "R7"; end
            else begin ecode = 8'h00; eaddr = va[63:0]; tag = "R6"; end

            @(negedge clk_i);
            check("R1 valid", 64'(rsp_valid_o), 1);
            check($sformatf("%s code s%0d k%0d w%0d f%0d", tag, s, k, w, f),
                  64'(rsp_exc_code_o), 64'(ecode));
            check($sformatf("%s addr s%0d k%0d w%0d f%0d", tag, s, k, w, f), rsp_addr_o, eaddr);
            check("R8 fault flag", 64'(rsp_fault_o), 64'(ecode != 8'h00));
            check("R8 reg num", 64'(rsp_reg_num_o), 0);
          end
        end
      end
    end

    // R5/R7 exact-edge spot checks, scenario 1 load with full perms
    last_addr = '0;
    for (int w = 0; w < 4; w++) begin
      scen(1, b, o, l, r);
      acc_kind_i = 2'd1; acc_width_i = 2'(w);
      cap_tag_i = 1; cap_sealed_i = 0; cap_perm_load_i = 1;
      raw_addr_i = r; cap_base_i = b; cap_offset_i = o; cap_length_i = l;
      req_valid_i = 1'b1;
      @(negedge clk_i);
      check("R5 edge size", 64'(rsp_exc_code_o), (w == 3) ? 64'h01 : 64'h00);
      last_addr = rsp_addr_o;
    end

    // R1 idle: no response, held outputs
    req_valid_i = 1'b0;
    cap_tag_i = 1'b0;
    raw_addr_i = 64'h55;
    @(negedge clk_i);
    check("R1 idle valid", 64'(rsp_valid_o), 0);
    check("R1 idle addr hold", rsp_addr_o, last_addr);
    check("R1 idle code hold", 64'(rsp_exc_code_o), 64'h01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule